// File: doc/BRIEF.md
# Trigger Setup Control Register

This block holds the trigger configuration of an oscilloscope front end and turns it into the digital select and control lines of the analog trigger path. A serial control chain presents a configuration word together with a strobe. The block splits that word between two registers. The source register is loaded on every clock, so it tracks the word with one cycle of delay and needs no strobe. The coupling register, which also holds slope, noise rejection and the auto-mode request, changes only in a cycle where the strobe is high.

The block decodes both 3-bit codes, folds reserved codes onto safe defaults and forces peak-to-peak auto mode whenever TV field coupling is chosen. It also gates a one-cycle processor trigger pulse so that the pulse reaches the trigger path only while the processor source is selected. The analog multiplexers, comparator and peak detectors that consume these outputs are not part of this block.

Configuration word layout: bits [2:0] source code, bits [5:3] coupling code, bit 6 slope, bit 7 noise reject, bit 8 auto request.

Top module: `trig_setup_ctrl`

## Requirements
- R1: `src_sel` takes the decoded source code of `cfg_word[2:0]` one clock after it is presented, whether `cfg_stb` is high or low.
- R2: `cpl_sel`, `slope_neg`, `hyst_level` and `pp_auto` change only on a clock edge where `cfg_stb` is high; otherwise they keep their values.
- R3: Source codes are 0 channel 1, 1 channel 2, 2 line, 3 external, 4 processor trigger; codes 5, 6 and 7 give `src_sel` = 0.
- R4: Coupling codes are 0 DC, 1 AC, 2 low-frequency reject, 3 high-frequency reject, 4 TV field; codes 5, 6 and 7 give `cpl_sel` = 0.
- R5: When the latched coupling is TV field (4), `pp_auto` is 1 whatever `cfg_word[8]`; for other couplings `pp_auto` equals the latched `cfg_word[8]`.
- R6: `hyst_level` is HYST_BASE (default 2) when the latched `cfg_word[7]` is 0 and four times HYST_BASE (default 8) when it is 1.
- R7: `slope_neg` equals the latched `cfg_word[6]` (0 rising edge, 1 falling edge).
- R8: `proc_trig_out` is high one clock after `proc_trig_in` is high, only if `src_sel` was 4 at that edge; otherwise it is low.
- R9: A synchronous active-high `rst` sets `src_sel` = 0, `cpl_sel` = 0, `slope_neg` = 0, `hyst_level` = HYST_BASE, `pp_auto` = 0 and `proc_trig_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 9 | Configuration word from the control chain |
| cfg_stb | input | 1 | Load strobe for the coupling register |
| proc_trig_in | input | 1 | One-cycle processor trigger pulse |
| src_sel | output | 3 | Decoded trigger source code |
| cpl_sel | output | 3 | Decoded trigger coupling code |
| slope_neg | output | 1 | 1 selects falling-edge triggering |
| hyst_level | output | 4 | Comparator hysteresis setting |
| pp_auto | output | 1 | Peak-to-peak auto mode enable |
| proc_trig_out | output | 1 | Gated processor trigger to the source path |

## Verification
The bench changes coupling fields with the strobe low and confirms the outputs stay put, which catches a design that loads both registers on every clock, and it changes the source with the strobe low, which catches a design that waits for the strobe on both. It drives every reserved code, where a missing fold would put 5 to 7 on the select lines. It selects TV field with the auto bit clear, where a missing override leaves `pp_auto` low, and it fires the processor pulse with another source selected, where a missing gate leaks a trigger.

// File: rtl/trig_setup_pkg.sv
package trig_setup_pkg;
  localparam int CODE_W = 3;

  localparam logic [CODE_W-1:0] SRC_CH1  = 3'd0;
  localparam logic [CODE_W-1:0] SRC_CH2  = 3'd1;
  localparam logic [CODE_W-1:0] SRC_LINE = 3'd2;
  localparam logic [CODE_W-1:0] SRC_EXT  = 3'd3;
  localparam logic [CODE_W-1:0] SRC_PROC = 3'd4;

  localparam logic [CODE_W-1:0] CPL_DC  = 3'd0;
  localparam logic [CODE_W-1:0] CPL_AC  = 3'd1;
  localparam logic [CODE_W-1:0] CPL_LFR = 3'd2;
  localparam logic [CODE_W-1:0] CPL_HFR = 3'd3;
  localparam logic [CODE_W-1:0] CPL_TV  = 3'd4;

  // field positions in the configuration word
  localparam int F_SRC_LO = 0;
  localparam int F_CPL_LO = CODE_W;
  localparam int F_SLOPE  = 2 * CODE_W;
  localparam int F_NREJ   = 2 * CODE_W + 1;
  localparam int F_AUTO   = 2 * CODE_W + 2;
  localparam int CFG_W    = 2 * CODE_W + 3;

  typedef struct packed {
    logic              auto_req;
    logic              noise_rej;
    logic              slope_neg;
    logic [CODE_W-1:0] cpl;
    logic [CODE_W-1:0] src;
  } cfg_t;
endpackage

// File: rtl/trig_src_reg.sv
module trig_src_reg
  import trig_setup_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] src_code,
  output logic [CODE_W-1:0] src_q
);
  logic [CODE_W-1:0] src_dec;

  always_comb begin
    if (src_code > SRC_PROC) src_dec = SRC_CH1;
    else                     src_dec = src_code;
  end

  // loaded every cycle: follows the chain without a strobe
  always_ff @(posedge clk) begin
    if (rst) src_q <= SRC_CH1;
    else     src_q <= src_dec;
  end

  a_r3_src_range: assert property (@(posedge clk) disable iff (rst)
    src_q <= SRC_PROC);
endmodule

// File: rtl/trig_cpl_reg.sv
module trig_cpl_reg
  import trig_setup_pkg::*;
#(
  parameter int HYST_W    = 4,
  parameter int HYST_BASE = 2
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [CODE_W-1:0] cpl_code,
  input  logic              slope_in,
  input  logic              nrej_in,
  input  logic              auto_in,
  output logic [CODE_W-1:0] cpl_q,
  output logic              slope_q,
  output logic [HYST_W-1:0] hyst_q,
  output logic              pp_auto_q
);
  localparam logic [HYST_W-1:0] H_NORM = HYST_W'(HYST_BASE);
  localparam logic [HYST_W-1:0] H_WIDE = HYST_W'(4 * HYST_BASE);

  logic [CODE_W-1:0] cpl_dec;
  logic              pp_dec;

  always_comb begin
    if (cpl_code > CPL_TV) cpl_dec = CPL_DC;
    else                   cpl_dec = cpl_code;
    pp_dec = auto_in || (cpl_dec == CPL_TV);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpl_q     <= CPL_DC;
      slope_q   <= 1'b0;
      hyst_q    <= H_NORM;
      pp_auto_q <= 1'b0;
    end else if (stb) begin
      cpl_q     <= cpl_dec;
      slope_q   <= slope_in;
      hyst_q    <= nrej_in ? H_WIDE : H_NORM;
      pp_auto_q <= pp_dec;
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !stb |=> ($stable(cpl_q) && $stable(slope_q) && $stable(hyst_q) && $stable(pp_auto_q)));
  a_r4_cpl_range: assert property (@(posedge clk) disable iff (rst)
    cpl_q <= CPL_TV);
  a_r5_tv_auto: assert property (@(posedge clk) disable iff (rst)
    (cpl_q == CPL_TV) |-> pp_auto_q);
  a_r6_hyst_vals: assert property (@(posedge clk) disable iff (rst)
    (hyst_q == H_NORM) || (hyst_q == H_WIDE));
  a_r7_slope_load: assert property (@(posedge clk) disable iff (rst)
    stb |=> (slope_q == $past(slope_in)));
endmodule

// File: rtl/trig_proc_gate.sv
module trig_proc_gate
  import trig_setup_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] src_sel,
  input  logic              pulse_in,
  output logic              pulse_out
);
  always_ff @(posedge clk) begin
    if (rst) pulse_out <= 1'b0;
    else     pulse_out <= pulse_in && (src_sel == SRC_PROC);
  end

  a_r8_gated: assert property (@(posedge clk) disable iff (rst)
    pulse_out |-> ($past(pulse_in) && ($past(src_sel) == SRC_PROC)));
endmodule

// File: rtl/trig_setup_ctrl.sv
module trig_setup_ctrl
  import trig_setup_pkg::*;
#(
  parameter int HYST_W    = 4,
  parameter int HYST_BASE = 2
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              cfg_stb,
  input  logic              proc_trig_in,
  output logic [CODE_W-1:0] src_sel,
  output logic [CODE_W-1:0] cpl_sel,
  output logic              slope_neg,
  output logic [HYST_W-1:0] hyst_level,
  output logic              pp_auto,
  output logic              proc_trig_out
);
  cfg_t cfg;
  assign cfg = cfg_t'(cfg_word);

  trig_src_reg u_src (
    .clk      (clk),
    .rst      (rst),
    .src_code (cfg.src),
    .src_q    (src_sel)
  );

  trig_cpl_reg #(.HYST_W(HYST_W), .HYST_BASE(HYST_BASE)) u_cpl (
    .clk       (clk),
    .rst       (rst),
    .stb       (cfg_stb),
    .cpl_code  (cfg.cpl),
    .slope_in  (cfg.slope_neg),
    .nrej_in   (cfg.noise_rej),
    .auto_in   (cfg.auto_req),
    .cpl_q     (cpl_sel),
    .slope_q   (slope_neg),
    .hyst_q    (hyst_level),
    .pp_auto_q (pp_auto)
  );

  trig_proc_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .src_sel   (src_sel),
    .pulse_in  (proc_trig_in),
    .pulse_out (proc_trig_out)
  );

  a_r1_src_follow: assert property (@(posedge clk) disable iff (rst)
    (cfg_word[F_SRC_LO +: CODE_W] <= SRC_PROC) |=> (src_sel == $past(cfg_word[F_SRC_LO +: CODE_W])));
  a_r9_reset: assert property (@(posedge clk)
    rst |=> ((src_sel == SRC_CH1) && (cpl_sel == CPL_DC) && !slope_neg && !pp_auto && !proc_trig_out));
endmodule

// File: tb/sim_trig_setup_ctrl.sv
module sim_trig_setup_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] cfg_word = '0;
  logic       cfg_stb = 1'b0;
  logic       proc_trig_in = 1'b0;
  logic [2:0] src_sel, cpl_sel;
  logic       slope_neg, pp_auto, proc_trig_out;
  logic [3:0] hyst_level;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  trig_setup_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .cfg_stb(cfg_stb),
    .proc_trig_in(proc_trig_in), .src_sel(src_sel), .cpl_sel(cpl_sel),
    .slope_neg(slope_neg), .hyst_level(hyst_level), .pp_auto(pp_auto),
    .proc_trig_out(proc_trig_out)
  );

  function automatic logic [8:0] mk(int s, int c, bit sl, bit nr, bit au);
    return {au, nr, sl, 3'(c), 3'(s)};
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 src", src_sel, 0);
    chk("R9 cpl", cpl_sel, 0);
    chk("R9 slope", slope_neg, 0);
    chk("R9 hyst", hyst_level, 2);
    chk("R9 pp", pp_auto, 0);
    chk("R9 ptrig", proc_trig_out, 0);
  endtask

  task automatic t_source();
    for (int s = 0; s < 8; s++) begin
      cfg_word = mk(s, 3, 1'b1, 1'b1, 1'b1);
      cfg_stb = 1'b0;
      @(negedge clk);
      chk("R1 R3 src", src_sel, (s > 4) ? 0 : s);
      chk("R2 cpl held", cpl_sel, 0);
      chk("R2 hyst held", hyst_level, 2);
    end
  endtask

  task automatic t_coupling();
    cfg_word = mk(0, 2, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk("R2 no stb", cpl_sel, 0);
    chk("R2 slope no stb", slope_neg, 0);
    cfg_stb = 1'b1;
    @(negedge clk);
    cfg_stb = 1'b0;
    chk("R4 cpl", cpl_sel, 2);
    chk("R7 slope", slope_neg, 1);
    cfg_word = mk(0, 1, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    @(negedge clk);
    chk("R2 held cpl", cpl_sel, 2);
    chk("R2 held slope", slope_neg, 1);
    chk("R2 held pp", pp_auto, 0);
    for (int c = 0; c < 8; c++) begin
      cfg_word = mk(0, c, 1'b0, 1'b0, 1'b0);
      cfg_stb = 1'b1;
      @(negedge clk);
      cfg_stb = 1'b0;
      chk("R4 decode", cpl_sel, (c > 4) ? 0 : c);
      chk("R7 slope rising", slope_neg, 0);
    end
  endtask

  task automatic t_tv();
    cfg_word = mk(0, 4, 1'b0, 1'b0, 1'b0);
    cfg_stb = 1'b1;
    @(negedge clk);
    chk("R5 tv cpl", cpl_sel, 4);
    chk("R5 tv forces pp", pp_auto, 1);
    cfg_word = mk(0, 1, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    chk("R5 auto bit", pp_auto, 1);
    cfg_word = mk(0, 1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    cfg_stb = 1'b0;
    chk("R5 no auto", pp_auto, 0);
  endtask

  task automatic t_hyst();
    cfg_word = mk(0, 0, 1'b0, 1'b1, 1'b0);
    cfg_stb = 1'b1;
    @(negedge clk);
    chk("R6 noise wide", hyst_level, 8);
    cfg_word = mk(0, 0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    cfg_stb = 1'b0;
    chk("R6 normal", hyst_level, 2);
  endtask

  task automatic t_ptrig();
    cfg_word = mk(4, 0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R8 src proc", src_sel, 4);
    proc_trig_in = 1'b1;
    @(negedge clk);
    proc_trig_in = 1'b0;
    chk("R8 pulse passes", proc_trig_out, 1);
    @(negedge clk);
    chk("R8 pulse one cycle", proc_trig_out, 0);
    cfg_word = mk(1, 0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    proc_trig_in = 1'b1;
    @(negedge clk);
    proc_trig_in = 1'b0;
    chk("R8 pulse blocked", proc_trig_out, 0);
  endtask

  task automatic t_midreset();
    cfg_word = mk(3, 4, 1'b1, 1'b1, 1'b1);
    cfg_stb = 1'b1;
    @(negedge clk);
    cfg_stb = 1'b0;
    cfg_word = mk(0, 0, 1'b0, 1'b0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 mid src", src_sel, 0);
    chk("R9 mid cpl", cpl_sel, 0);
    chk("R9 mid slope", slope_neg, 0);
    chk("R9 mid hyst", hyst_level, 2);
    chk("R9 mid pp", pp_auto, 0);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_source();
        t_coupling();
        t_tv();
        t_hyst();
        t_ptrig();
        t_midreset();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule